// File: doc/BRIEF.md
# Multi-Host Memory Section Allocator

A command engine that hands out fixed-size memory sections to several host heads sharing one memory device. It keeps an ownership table holding one head bitmask per section, plus a count of free sections. A requesting head issues an allocate or a release over a valid/ready command port. All requests pass through this single port, so every read-modify-write of a section's mask is atomic with respect to the other heads.

An allocation can use one of three policies. All-or-nothing either claims the full request or undoes its partial claims. Best-effort claims as many sections as it finds. Manual claims the sections named in a list of extents. The sections claimed by a request are reported as a stream of coalesced extents, each a start index and a length. A one-cycle done pulse then carries the status and the number of sections affected. A release clears the requester's bit over a list of extents.

Top module: `sect_alloc`

## Requirements
- R1: After reset `cmd_ready_o` is 1, `done_o` is 0, `ext_valid_o` is 0, `free_cnt_o` equals NSECT and every section mask is zero.
- R2: A command is rejected with status 1 (invalid), result count 0 and no state change in any of these cases: the extent number is above MAX_EXT; an extent starts at or beyond NSECT; an extent ends beyond NSECT; an allocate has count 0 or a count above NSECT; an allocate has policy 3.
- R3: An allocate claims a section only when the section's whole mask is zero. A section already owned by the requester, or owned by any other head, is skipped and not counted.
- R4: `free_cnt_o` drops by one for each claim and rises by one for each cleared bit. It changes by at most one per cycle and never exceeds NSECT.
- R5: `cmd_policy_i` encodes 0 as all-or-nothing, 1 as best-effort and 2 as manual. `cmd_release_i` set to 1 selects release, and when it is 1 the policy and count fields are ignored.
- R6: Best-effort and all-or-nothing scan section indices upward from 0. The scan stops as soon as the requested number has been claimed. A best-effort shortfall still completes with status 0.
- R7: An all-or-nothing shortfall clears exactly the sections claimed by that request and restores `free_cnt_o`. It completes with status 2, result count 0 and no extents.
- R8: Under the manual policy the extent lengths must sum to the count, or R2 applies. Sections are tried extent by extent in list order, each extent from its start upward.
- R9: A successful allocate emits its claimed indices in claim order as extents, one per `ext_valid_o` cycle, with the last one no later than the done cycle. A new extent starts whenever an index is not exactly one more than the previous one, and a wrap from NSECT-1 to 0 does not merge.
- R10: A release clears the requester's bit in each listed section. The result count is the number of bits that were actually set. Sections not owned by the requester are left unchanged. Status is 0.
- R11: `cmd_ready_o` is 0 from the cycle after acceptance until the cycle after done. Command inputs presented while it is 0 are ignored.
- R12: `done_o` is a single-cycle pulse with `status_o` (0 ok, 1 invalid, 2 shortfall) and `res_cnt_o` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Engine idle, command accepted when valid |
| cmd_release_i | input | 1 | 1 release, 0 allocate |
| cmd_head_i | input | HEAD_W | Requesting head |
| cmd_policy_i | input | 2 | Allocation policy code |
| cmd_count_i | input | CNT_W | Sections requested |
| cmd_ext_num_i | input | EXT_W | Number of valid extents in the list |
| cmd_ext_start_i | input | MAX_EXT*IDX_W | Extent start indices, extent e at bits e*IDX_W |
| cmd_ext_len_i | input | MAX_EXT*CNT_W | Extent lengths, extent e at bits e*CNT_W |
| done_o | output | 1 | Completion pulse |
| status_o | output | 2 | Completion status |
| res_cnt_o | output | CNT_W | Sections claimed or released |
| ext_valid_o | output | 1 | Result extent valid |
| ext_start_o | output | IDX_W | Result extent start |
| ext_len_o | output | CNT_W | Result extent length |
| free_cnt_o | output | CNT_W | Free sections in the table |

## Verification
Directed sequences build up ownership by one head and then let other heads hit those sections. This separates the three skip cases (free, own, foreign). It also checks that a best-effort result splits into several extents around foreign holes. Manual lists in descending order, and one that wraps from the last index to 0, tell claim-order coalescing apart from index-order or modular merging. An all-or-nothing request larger than the free pool is followed by further allocations. This shows that the rollback cleared only the indices it had claimed. Random traffic from all heads is then compared with a reference ownership model, with garbage held on the command inputs while the engine is busy.

// File: rtl/sect_alloc_pkg.sv
package sect_alloc_pkg;
  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_INVALID = 2'd1;
  localparam logic [1:0] ST_SHORT   = 2'd2;

  localparam logic [1:0] POL_AON    = 2'd0;
  localparam logic [1:0] POL_BEST   = 2'd1;
  localparam logic [1:0] POL_MANUAL = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_UNDO, S_EMIT, S_DONE} state_e;
endpackage

// File: rtl/sect_req_check.sv
module sect_req_check
  import sect_alloc_pkg::*;
#(
  parameter int NSECT   = 16,
  parameter int MAX_EXT = 4,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 5,
  parameter int EXT_W   = 3
) (
  input  logic                     release_i,
  input  logic [1:0]               policy_i,
  input  logic [CNT_W-1:0]         count_i,
  input  logic [EXT_W-1:0]         ext_num_i,
  input  logic [MAX_EXT*IDX_W-1:0] ext_start_i,
  input  logic [MAX_EXT*CNT_W-1:0] ext_len_i,
  output logic                     bad_o
);
  localparam int SUM_W = CNT_W + EXT_W;

  logic [SUM_W-1:0] sum;
  logic [CNT_W:0]   endp;

  always_comb begin
    bad_o = 1'b0;
    sum   = '0;
    endp  = '0;
    if (ext_num_i > EXT_W'(MAX_EXT)) bad_o = 1'b1;
    for (int e = 0; e < MAX_EXT; e++) begin
      if (e < int'(ext_num_i)) begin
        endp = (CNT_W+1)'(ext_start_i[e*IDX_W +: IDX_W]) + (CNT_W+1)'(ext_len_i[e*CNT_W +: CNT_W]);
        if (CNT_W'(ext_start_i[e*IDX_W +: IDX_W]) >= CNT_W'(NSECT)) bad_o = 1'b1;
        if (endp > (CNT_W+1)'(NSECT)) bad_o = 1'b1;
        sum = sum + SUM_W'(ext_len_i[e*CNT_W +: CNT_W]);
      end
    end
    if (!release_i) begin
      if (count_i == '0 || count_i > CNT_W'(NSECT)) bad_o = 1'b1;
      if (policy_i == 2'd3) bad_o = 1'b1;
      if (policy_i == POL_MANUAL && sum != SUM_W'(count_i)) bad_o = 1'b1;
    end
  end
endmodule

// File: rtl/sect_table.sv
module sect_table #(
  parameter int NSECT  = 16,
  parameter int NH     = 4,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 5,
  parameter int HEAD_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_en_i,
  input  logic              acc_drop_i,
  input  logic [IDX_W-1:0]  acc_idx_i,
  input  logic [HEAD_W-1:0] acc_head_i,
  output logic              hit_o,
  output logic [CNT_W-1:0]  free_cnt_o
);
  logic [NH-1:0]    own_q [NSECT];
  logic [NH-1:0]    cur;
  logic [CNT_W-1:0] free_q;

  assign cur        = own_q[acc_idx_i];
  // claim wins only on an all-zero mask; drop hits only if our bit is set
  assign hit_o      = acc_drop_i ? cur[acc_head_i] : (cur == '0);
  assign free_cnt_o = free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSECT; s++) own_q[s] <= '0;
      free_q <= CNT_W'(NSECT);
    end else if (acc_en_i && hit_o) begin
      if (acc_drop_i) begin
        own_q[acc_idx_i][acc_head_i] <= 1'b0;
        free_q <= free_q + 1'b1;
      end else begin
        own_q[acc_idx_i][acc_head_i] <= 1'b1;
        free_q <= free_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sect_claim_log.sv
module sect_claim_log #(
  parameter int NSECT = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [IDX_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [IDX_W-1:0] rd_data_o
);
  logic [IDX_W-1:0] mem [NSECT];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/sect_alloc.sv
module sect_alloc
  import sect_alloc_pkg::*;
#(
  parameter int NSECT   = 16,
  parameter int NH      = 4,
  parameter int MAX_EXT = 4,
  localparam int IDX_W  = $clog2(NSECT),
  localparam int CNT_W  = $clog2(NSECT + 1),
  localparam int HEAD_W = (NH > 1) ? $clog2(NH) : 1,
  localparam int EXT_W  = $clog2(MAX_EXT + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_valid_i,
  output logic                     cmd_ready_o,
  input  logic                     cmd_release_i,
  input  logic [HEAD_W-1:0]        cmd_head_i,
  input  logic [1:0]               cmd_policy_i,
  input  logic [CNT_W-1:0]         cmd_count_i,
  input  logic [EXT_W-1:0]         cmd_ext_num_i,
  input  logic [MAX_EXT*IDX_W-1:0] cmd_ext_start_i,
  input  logic [MAX_EXT*CNT_W-1:0] cmd_ext_len_i,
  output logic                     done_o,
  output logic [1:0]               status_o,
  output logic [CNT_W-1:0]         res_cnt_o,
  output logic                     ext_valid_o,
  output logic [IDX_W-1:0]         ext_start_o,
  output logic [CNT_W-1:0]         ext_len_o,
  output logic [CNT_W-1:0]         free_cnt_o
);
  state_e           state_q;
  logic             op_q;
  logic [1:0]       pol_q;
  logic [HEAD_W-1:0] head_q;
  logic [CNT_W-1:0] want_q, got_q, idx_q, off_q, pos_q, res_q, run_len_q, xl_q;
  logic [IDX_W-1:0] est_q [MAX_EXT];
  logic [CNT_W-1:0] elen_q [MAX_EXT];
  logic [EXT_W-1:0] enum_q, ei_q, ei_sel;
  logic [IDX_W-1:0] run_start_q, last_q, xs_q;
  logic [1:0]       status_q;
  logic             xv_q;

  logic             bad, walk_mode, walk_end, off_done, scan_fin, new_run;
  logic             acc_en, acc_drop, hit, log_we;
  logic [IDX_W-1:0] acc_idx, walk_sec, log_rd;

  sect_req_check #(.NSECT(NSECT), .MAX_EXT(MAX_EXT), .IDX_W(IDX_W), .CNT_W(CNT_W),
                   .EXT_W(EXT_W)) u_check (
    .release_i(cmd_release_i), .policy_i(cmd_policy_i), .count_i(cmd_count_i),
    .ext_num_i(cmd_ext_num_i), .ext_start_i(cmd_ext_start_i), .ext_len_i(cmd_ext_len_i),
    .bad_o(bad));

  sect_table #(.NSECT(NSECT), .NH(NH), .IDX_W(IDX_W), .CNT_W(CNT_W), .HEAD_W(HEAD_W)) u_table (
    .clk_i, .rst_ni, .acc_en_i(acc_en), .acc_drop_i(acc_drop), .acc_idx_i(acc_idx),
    .acc_head_i(head_q), .hit_o(hit), .free_cnt_o(free_cnt_o));

  sect_claim_log #(.NSECT(NSECT), .IDX_W(IDX_W)) u_log (
    .clk_i, .wr_en_i(log_we), .wr_addr_i(got_q[IDX_W-1:0]), .wr_data_i(acc_idx),
    .rd_addr_i(pos_q[IDX_W-1:0]), .rd_data_o(log_rd));

  assign walk_mode = op_q || (pol_q == POL_MANUAL);
  assign walk_end  = (ei_q == enum_q);
  assign ei_sel    = walk_end ? '0 : ei_q;
  assign walk_sec  = est_q[ei_sel] + off_q[IDX_W-1:0];
  assign off_done  = (off_q == elen_q[ei_sel]);
  assign scan_fin  = walk_mode ? walk_end : (got_q == want_q || idx_q == CNT_W'(NSECT));
  assign new_run   = (pos_q == '0) || ({1'b0, log_rd} != {1'b0, last_q} + 1'b1);

  always_comb begin
    acc_en   = 1'b0;
    acc_drop = 1'b0;
    acc_idx  = '0;
    if (state_q == S_SCAN && !scan_fin) begin
      if (walk_mode) begin
        acc_en   = !off_done;
        acc_drop = op_q;
        acc_idx  = walk_sec;
      end else begin
        acc_en  = 1'b1;
        acc_idx = idx_q[IDX_W-1:0];
      end
    end else if (state_q == S_UNDO && pos_q != got_q) begin
      acc_en   = 1'b1;
      acc_drop = 1'b1;
      acc_idx  = log_rd;
    end
  end

  assign log_we = (state_q == S_SCAN) && acc_en && !acc_drop && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q <= 1'b0; pol_q <= '0; head_q <= '0; want_q <= '0; got_q <= '0;
      idx_q <= '0; off_q <= '0; pos_q <= '0; res_q <= '0; enum_q <= '0; ei_q <= '0;
      run_start_q <= '0; run_len_q <= '0; last_q <= '0; status_q <= ST_OK;
      xv_q <= 1'b0; xs_q <= '0; xl_q <= '0;
      for (int e = 0; e < MAX_EXT; e++) begin
        est_q[e]  <= '0;
        elen_q[e] <= '0;
      end
    end else begin
      xv_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          op_q   <= cmd_release_i;
          pol_q  <= cmd_policy_i;
          head_q <= cmd_head_i;
          want_q <= cmd_count_i;
          enum_q <= cmd_ext_num_i;
          for (int e = 0; e < MAX_EXT; e++) begin
            est_q[e]  <= cmd_ext_start_i[e*IDX_W +: IDX_W];
            elen_q[e] <= cmd_ext_len_i[e*CNT_W +: CNT_W];
          end
          got_q <= '0; idx_q <= '0; ei_q <= '0; off_q <= '0; pos_q <= '0;
          if (bad) begin
            status_q <= ST_INVALID;
            res_q    <= '0;
            state_q  <= S_DONE;
          end else begin
            state_q <= S_SCAN;
          end
        end
        S_SCAN: if (scan_fin) begin
          pos_q <= '0;
          if (op_q) begin
            status_q <= ST_OK;
            res_q    <= got_q;
            state_q  <= S_DONE;
          end else if (pol_q == POL_AON && got_q != want_q) begin
            state_q <= S_UNDO;
          end else begin
            state_q <= S_EMIT;
          end
        end else begin
          if (acc_en && hit) got_q <= got_q + 1'b1;
          if (!walk_mode)    idx_q <= idx_q + 1'b1;
          else if (off_done) begin
            ei_q  <= ei_q + 1'b1;
            off_q <= '0;
          end else           off_q <= off_q + 1'b1;
        end
        S_UNDO: if (pos_q == got_q) begin
          status_q <= ST_SHORT;
          res_q    <= '0;
          state_q  <= S_DONE;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
        S_EMIT: if (pos_q == got_q) begin
          xv_q     <= (got_q != '0);
          xs_q     <= run_start_q;
          xl_q     <= run_len_q;
          status_q <= ST_OK;
          res_q    <= got_q;
          state_q  <= S_DONE;
        end else begin
          if (new_run) begin
            xv_q        <= (pos_q != '0);
            xs_q        <= run_start_q;
            xl_q        <= run_len_q;
            run_start_q <= log_rd;
            run_len_q   <= CNT_W'(1);
          end else begin
            run_len_q <= run_len_q + 1'b1;
          end
          last_q <= log_rd;
          pos_q  <= pos_q + 1'b1;
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign status_o    = status_q;
  assign res_cnt_o   = res_q;
  assign ext_valid_o = xv_q;
  assign ext_start_o = xs_q;
  assign ext_len_o   = xl_q;
endmodule

// File: rtl/sect_alloc_chk.sv
module sect_alloc_chk #(
  parameter int NSECT = 16,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_ready_o,
  input logic             done_o,
  input logic [1:0]       status_o,
  input logic [CNT_W-1:0] res_cnt_o,
  input logic             ext_valid_o,
  input logic [CNT_W-1:0] ext_len_o,
  input logic [CNT_W-1:0] free_cnt_o
);
  a_r4_free_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt_o <= CNT_W'(NSECT));

  a_r4_free_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, free_cnt_o} == {1'b0, $past(free_cnt_o)}) ||
    ({1'b0, free_cnt_o} == {1'b0, $past(free_cnt_o)} + 1'b1) ||
    ({1'b0, free_cnt_o} + 1'b1 == {1'b0, $past(free_cnt_o)}));

  a_r11_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && $past(cmd_ready_o)) |-> $stable(free_cnt_o));

  a_r11_busy_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_ready_o);

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_invalid_nochange: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd1) |-> (res_cnt_o == '0 && $stable(free_cnt_o)));

  a_r7_short_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd2) |-> (res_cnt_o == '0 && !ext_valid_o));

  a_r9_ext_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |-> (!cmd_ready_o && ext_len_o != '0));
endmodule

bind sect_alloc sect_alloc_chk #(.NSECT(NSECT), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_ready_o(cmd_ready_o), .done_o(done_o),
  .status_o(status_o), .res_cnt_o(res_cnt_o), .ext_valid_o(ext_valid_o),
  .ext_len_o(ext_len_o), .free_cnt_o(free_cnt_o));

// File: tb/sect_alloc_test.sv
module sect_alloc_test;
  localparam int NSECT   = 16;
  localparam int NH      = 4;
  localparam int MAX_EXT = 4;
  localparam int IDX_W   = 4;
  localparam int CNT_W   = 5;
  localparam int HEAD_W  = 2;
  localparam int EXT_W   = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic                     cmd_valid, cmd_ready, cmd_release;
  logic [HEAD_W-1:0]        cmd_head;
  logic [1:0]               cmd_policy;
  logic [CNT_W-1:0]         cmd_count;
  logic [EXT_W-1:0]         cmd_ext_num;
  logic [MAX_EXT*IDX_W-1:0] cmd_ext_start;
  logic [MAX_EXT*CNT_W-1:0] cmd_ext_len;
  logic                     done, ext_valid;
  logic [1:0]               status;
  logic [CNT_W-1:0]         res_cnt, ext_len, free_cnt;
  logic [IDX_W-1:0]         ext_start;

  sect_alloc #(.NSECT(NSECT), .NH(NH), .MAX_EXT(MAX_EXT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_release_i(cmd_release), .cmd_head_i(cmd_head), .cmd_policy_i(cmd_policy),
    .cmd_count_i(cmd_count), .cmd_ext_num_i(cmd_ext_num), .cmd_ext_start_i(cmd_ext_start),
    .cmd_ext_len_i(cmd_ext_len), .done_o(done), .status_o(status), .res_cnt_o(res_cnt),
    .ext_valid_o(ext_valid), .ext_start_o(ext_start), .ext_len_o(ext_len),
    .free_cnt_o(free_cnt));

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  // reference model state
  bit [NH-1:0] m_own [NSECT];
  int m_free;
  // command under test
  int c_rel, c_head, c_pol, c_cnt, c_num;
  int c_st [MAX_EXT];
  int c_ln [MAX_EXT];
  // expected / observed results
  int e_status, e_cnt, e_xn, o_xn;
  int e_xs [NSECT];
  int e_xl [NSECT];
  int o_xs [NSECT];
  int o_xl [NSECT];

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model();
    int rec [NSECT];
    int got = 0, sum = 0;
    bit bad = 0;
    if (c_num > MAX_EXT) bad = 1;
    for (int e = 0; e < MAX_EXT; e++)
      if (e < c_num) begin
        if (c_st[e] >= NSECT || c_st[e] + c_ln[e] > NSECT) bad = 1;
        sum += c_ln[e];
      end
    if (!c_rel && (c_cnt == 0 || c_cnt > NSECT || c_pol == 3 || (c_pol == 2 && sum != c_cnt)))
      bad = 1;
    e_xn = 0;
    if (bad) begin
      e_status = 1; e_cnt = 0; return;
    end
    if (c_rel) begin
      for (int e = 0; e < c_num; e++)
        for (int j = 0; j < c_ln[e]; j++)
          if (m_own[c_st[e]+j][c_head]) begin
            m_own[c_st[e]+j][c_head] = 0; m_free++; got++;
          end
      e_status = 0; e_cnt = got; return;
    end
    if (c_pol == 2) begin
      for (int e = 0; e < c_num; e++)
        for (int j = 0; j < c_ln[e]; j++)
          if (m_own[c_st[e]+j] == 0) begin
            m_own[c_st[e]+j][c_head] = 1; m_free--; rec[got++] = c_st[e]+j;
          end
    end else begin
      for (int s = 0; s < NSECT && got < c_cnt; s++)
        if (m_own[s] == 0) begin
          m_own[s][c_head] = 1; m_free--; rec[got++] = s;
        end
    end
    if (c_pol == 0 && got < c_cnt) begin
      for (int k = 0; k < got; k++) begin
        m_own[rec[k]][c_head] = 0; m_free++;
      end
      e_status = 2; e_cnt = 0; return;
    end
    e_status = 0; e_cnt = got;
    for (int k = 0; k < got; k++) begin
      if (k == 0 || rec[k] != rec[k-1] + 1) begin
        e_xs[e_xn] = rec[k]; e_xl[e_xn] = 1; e_xn++;
      end else e_xl[e_xn-1]++;
    end
  endtask

  task automatic drive_garbage();
    cmd_release   = 1'($urandom);
    cmd_head      = HEAD_W'($urandom);
    cmd_policy    = 2'($urandom);
    cmd_count     = CNT_W'($urandom);
    cmd_ext_num   = EXT_W'($urandom);
    cmd_ext_start = (MAX_EXT*IDX_W)'($urandom);
    cmd_ext_len   = (MAX_EXT*CNT_W)'($urandom);
  endtask

  task automatic run(input string tag);
    cmd_release = 1'(c_rel);
    cmd_head    = HEAD_W'(c_head);
    cmd_policy  = 2'(c_pol);
    cmd_count   = CNT_W'(c_cnt);
    cmd_ext_num = EXT_W'(c_num);
    for (int e = 0; e < MAX_EXT; e++) begin
      cmd_ext_start[e*IDX_W +: IDX_W] = IDX_W'(c_st[e]);
      cmd_ext_len[e*CNT_W +: CNT_W]   = CNT_W'(c_ln[e]);
    end
    cmd_valid = 1'b1;
    model();
    @(negedge clk);
    chk({tag, " R11 ready low after accept"}, int'(cmd_ready), 0);
    drive_garbage();  // R11: held valid with garbage while busy must be ignored
    o_xn = 0;
    forever begin
      if (ext_valid && o_xn < NSECT) begin
        o_xs[o_xn] = int'(ext_start); o_xl[o_xn] = int'(ext_len); o_xn++;
      end
      if (done) break;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk({tag, " R12 status"}, int'(status), e_status);
    chk({tag, " R12 result count"}, int'(res_cnt), e_cnt);
    chk({tag, " R4 free count"}, int'(free_cnt), m_free);
    chk({tag, " R9 extent count"}, o_xn, e_xn);
    if (o_xn == e_xn)
      for (int k = 0; k < e_xn; k++) begin
        chk({tag, " R9 extent start"}, o_xs[k], e_xs[k]);
        chk({tag, " R9 extent length"}, o_xl[k], e_xl[k]);
      end
    @(negedge clk);
    chk({tag, " R12 done single cycle"}, int'(done), 0);
  endtask

  task automatic set_cmd(input int rel, input int head, input int pol, input int cnt, input int num);
    c_rel = rel; c_head = head; c_pol = pol; c_cnt = cnt; c_num = num;
    for (int e = 0; e < MAX_EXT; e++) begin
      c_st[e] = 0; c_ln[e] = 0;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    cmd_valid = 1'b0;
    set_cmd(0, 0, 0, 0, 0);
    drive_garbage();
    for (int s = 0; s < NSECT; s++) m_own[s] = '0;
    m_free = NSECT;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(cmd_ready), 1);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 ext_valid after reset", int'(ext_valid), 0);
    chk("R1 free after reset", int'(free_cnt), NSECT);

    set_cmd(0, 0, 1, 3, 0); run("R6 best-effort 3");
    set_cmd(0, 1, 0, 2, 0); run("R5 all-or-nothing 2");
    set_cmd(1, 0, 0, 0, 1); c_st[0] = 1; c_ln[0] = 1; run("R10 release own");
    set_cmd(0, 2, 1, 3, 0); run("R9 split around hole");
    set_cmd(1, 1, 0, 0, 1); c_st[0] = 0; c_ln[0] = 1; run("R10 release foreign ignored");
    set_cmd(0, 0, 2, 3, 2); c_st[0] = 2; c_ln[0] = 1; c_st[1] = 0; c_ln[1] = 2;
    run("R3 manual own and foreign skipped");
    set_cmd(0, 3, 2, 4, 2); c_st[0] = 10; c_ln[0] = 2; c_st[1] = 8; c_ln[1] = 2;
    run("R8 manual descending order");
    set_cmd(0, 3, 2, 2, 2); c_st[0] = 15; c_ln[0] = 1; c_st[1] = 0; c_ln[1] = 1;
    run("R9 no wrap merge");
    set_cmd(0, 1, 2, 2, 1); c_st[0] = 12; c_ln[0] = 3; run("R8 length sum mismatch");
    set_cmd(0, 1, 1, 0, 0); run("R2 zero count");
    set_cmd(0, 1, 1, 17, 0); run("R2 count above total");
    set_cmd(0, 1, 3, 2, 0); run("R2 policy 3");
    set_cmd(1, 1, 0, 0, 5); run("R2 too many extents");
    set_cmd(1, 1, 0, 0, 1); c_st[0] = 14; c_ln[0] = 3; run("R2 extent past end");
    set_cmd(0, 3, 0, 16, 0); run("R7 all-or-nothing shortfall");
    set_cmd(0, 2, 1, 16, 0); run("R6 best-effort shortfall after rollback");
    set_cmd(0, 1, 0, 1, 0); run("R7 full pool short");

    for (int n = 0; n < 250; n++) begin
      int r;
      r = int'($urandom % 8);
      set_cmd(r < 3 ? 1 : 0, int'($urandom % NH), int'($urandom % 3), 1 + int'($urandom % 6),
              1 + int'($urandom % MAX_EXT));
      for (int e = 0; e < c_num; e++) begin
        c_st[e] = int'($urandom % NSECT);
        c_ln[e] = int'($urandom % (NSECT - c_st[e] + 1)) % 5;
      end
      if (c_pol == 2 && r != 7) begin
        c_cnt = 0;
        for (int e = 0; e < c_num; e++) c_cnt += c_ln[e];
      end
      if (r == 6) c_cnt = 0;
      run("R3 random traffic");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule